// File: doc/BRIEF.md
# Two-Wire Register-Write Target

This block is the target side of a two-wire serial bus. It carries register write transactions only. A fast system clock oversamples the clock line and the data line. The block recognises the bus START and STOP conditions and checks the first byte for its own 7-bit device address with the write direction. It then takes a register-address byte and accepts it only when that register is implemented.

After an accepted register address, every later byte is acknowledged. Each one appears on a parallel write port as a single-cycle strobe, together with the current register address and the byte. The address then advances by one, so a controller can fill consecutive registers in one burst that ends with STOP. The block answers on the data line only through an open-drain pull-down enable. A refused byte leaves the block deaf to the bus until the next START or STOP.

Top module: `i2c_regwr_target`

## Requirements
- R1: After reset the pull-down enable `sda_oe` is 0 and `wr_strobe` is 0.
- R2: The first byte after START is acknowledged (data line held low during the ninth clock pulse) only when its upper seven bits, sent most-significant bit first, equal `DEV_ADDR` and its last bit is 0 (write).
- R3: A first byte whose address matches but whose last bit is 1 (read) is not acknowledged.
- R4: The second byte is acknowledged only when its value is below `REG_COUNT`.
- R5: Every byte after an accepted register address is acknowledged and produces exactly one `wr_strobe` cycle with `wr_addr` and `wr_data` holding the register address and the byte.
- R6: Within one burst, `wr_addr` rises by one for each successive data byte.
- R7: After a refused byte, later bytes in the same transaction get no acknowledge and no strobe.
- R8: A repeated START in the middle of a transaction releases the data line and restarts device-address matching.
- R9: A STOP ends the transaction. A data byte cut short by STOP produces no strobe.
- R10: `sda_oe` changes only while the synchronised clock line is low. It is never asserted during the eight data bits of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| wr_strobe | output | 1 | One-cycle register write pulse |
| wr_addr | output | 8 | Register address of the write |
| wr_data | output | 8 | Data byte of the write |

## Verification
The bench walks all 128 device addresses and a spread of register addresses on both sides of `REG_COUNT`, including 0, the last valid register, the first invalid one and 255. An off-by-one in the register limit would acknowledge or refuse the wrong boundary register. A loose address compare would answer foreign devices or reads. Refused transactions are followed by data bytes, which catches a design that recovers from a not-acknowledge before the next START or STOP. A burst, a repeated START after a refused address, and a STOP in the middle of a byte expose pointers that fail to advance, matching that fails to restart, and strobes raised for partial bytes.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
   localparam int BYTE_W = 8;
   localparam int BIT_CW = 4;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_REG,
      ST_DATA,
      ST_IGNORE
   } phase_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_p, sda_p;

   generate
      if (STAGES < 2) begin : g_bad
         $error("i2c_bus_sampler: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_p <= scl_q[STAGES-1];
         sda_p <= sda_q[STAGES-1];
      end
   end

   assign scl_s     = scl_q[STAGES-1];
   assign sda_s     = sda_q[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_reg_range.sv
module i2c_reg_range #(
   parameter int AW        = 8,
   parameter int REG_COUNT = 24
) (
   input  logic [AW-1:0] addr,
   output logic          valid
);
   localparam int SPACE = 1 << AW;

   generate
      if (REG_COUNT < 1 || REG_COUNT > SPACE) begin : g_bad
         $error("i2c_reg_range: REG_COUNT out of range");
      end
      if (REG_COUNT == SPACE) begin : g_full
         assign valid = 1'b1;
      end else begin : g_part
         assign valid = (int'(addr) < REG_COUNT);
      end
   endgenerate
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
   import i2c_regwr_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2A,
   parameter int         REG_COUNT   = 24,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   output logic              wr_strobe,
   output logic [BYTE_W-1:0] wr_addr,
   output logic [BYTE_W-1:0] wr_data
);
   localparam logic [BIT_CW-1:0] FULL = BIT_CW'(BYTE_W);

   logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic reg_ok;

   phase_t              st;
   logic                ack_phase;
   logic [BIT_CW-1:0]   bit_cnt;
   logic [BYTE_W-1:0]   shreg;
   logic [BYTE_W-1:0]   reg_ptr;

   i2c_bus_sampler #(.STAGES(SYNC_STAGES)) u_samp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   i2c_reg_range #(.AW(BYTE_W), .REG_COUNT(REG_COUNT)) u_range (
      .addr(shreg), .valid(reg_ok)
   );

   wire receiving = (st == ST_DEV) || (st == ST_REG) || (st == ST_DATA);
   wire byte_end  = receiving && !ack_phase && scl_fall && (bit_cnt == FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         ack_phase <= 1'b0;
         bit_cnt   <= '0;
         shreg     <= '0;
         reg_ptr   <= '0;
         sda_oe    <= 1'b0;
         wr_strobe <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
      end else begin
         wr_strobe <= 1'b0;
         if (start_evt) begin
            st        <= ST_DEV;
            ack_phase <= 1'b0;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
         end else if (stop_evt) begin
            st        <= ST_IDLE;
            ack_phase <= 1'b0;
            bit_cnt   <= '0;
            sda_oe    <= 1'b0;
         end else if (receiving) begin
            if (ack_phase) begin
               if (scl_fall) begin
                  sda_oe    <= 1'b0;
                  ack_phase <= 1'b0;
                  bit_cnt   <= '0;
               end
            end else if (scl_rise && bit_cnt < FULL) begin
               shreg   <= {shreg[BYTE_W-2:0], sda_s};
               bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
               unique case (st)
                  ST_DEV: begin
                     if (shreg[BYTE_W-1:1] == DEV_ADDR && !shreg[0]) begin
                        sda_oe    <= 1'b1;
                        ack_phase <= 1'b1;
                        st        <= ST_REG;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
                  ST_REG: begin
                     if (reg_ok) begin
                        reg_ptr   <= shreg;
                        sda_oe    <= 1'b1;
                        ack_phase <= 1'b1;
                        st        <= ST_DATA;
                     end else begin
                        st <= ST_IGNORE;
                     end
                  end
                  default: begin
                     sda_oe    <= 1'b1;
                     ack_phase <= 1'b1;
                     wr_strobe <= 1'b1;
                     wr_addr   <= reg_ptr;
                     wr_data   <= shreg;
                     reg_ptr   <= reg_ptr + 1'b1;
                  end
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/i2c_regwr_chk.sv
module i2c_regwr_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_s,
   input logic       start_evt,
   input logic       stop_evt,
   input logic       sda_oe,
   input logic       wr_strobe,
   input logic [7:0] wr_addr
);
   logic       chain_ok;
   logic [7:0] next_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_ok  <= 1'b0;
         next_addr <= '0;
      end else if (start_evt || stop_evt) begin
         chain_ok <= 1'b0;
      end else if (wr_strobe) begin
         chain_ok  <= 1'b1;
         next_addr <= wr_addr + 8'd1;
      end
   end

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s) else $error("oe moved with clock high"); // R10
   AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |=> !wr_strobe) else $error("strobe too long"); // R5
   AST_STROBE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe |-> sda_oe) else $error("strobe without ack"); // R5
   AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      start_evt |=> !sda_oe) else $error("line held after start"); // R8
   AST_STOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> (!sda_oe && !wr_strobe)) else $error("activity after stop"); // R9
   AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_strobe && chain_ok) |-> (wr_addr == next_addr)) else $error("burst skip"); // R6
endmodule

bind i2c_regwr_target i2c_regwr_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
   .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_strobe(wr_strobe), .wr_addr(wr_addr)
);

// File: tb/tb_i2c_regwr_target.sv
module tb_i2c_regwr_target;
   localparam logic [6:0] DEV = 7'h2A;
   localparam int NREG = 24;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_oe, wr_strobe;
   logic [7:0] wr_addr, wr_data;
   wire  sda_ln = sda_m & ~sda_oe;

   int total = 0;
   int bad = 0;
   int ncap = 0;
   logic [7:0] cap_a [64];
   logic [7:0] cap_d [64];

   always #5 clk = ~clk;

   i2c_regwr_target #(.DEV_ADDR(DEV), .REG_COUNT(NREG), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_ln),
      .sda_oe(sda_oe), .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   always @(posedge clk) begin
      if (wr_strobe) begin
         cap_a[ncap % 64] <= wr_addr;
         cap_d[ncap % 64] <= wr_data;
         ncap <= ncap + 1;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      if (!scl_m) begin
         sda_m = 1'b1; wq();
         scl_m = 1'b1; wq();
      end
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic put_bit(input logic b, output logic seen_oe);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      seen_oe = sda_oe; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic o;
      logic leak;
      leak = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         put_bit(b[i], o);
         if (o) leak = 1'b1;
      end
      chk(!leak, "R10 oe during data bits", int'(leak), 0);
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq();
      ack = ~sda_ln; wq();
      scl_m = 1'b0; wq();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic ack;
      int n0;
      repeat (3) @(negedge clk);
      chk(sda_oe == 1'b0 && wr_strobe == 1'b0, "R1 reset outputs", int'({sda_oe, wr_strobe}), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R2 device address sweep
      for (int a = 0; a < 128; a++) begin
         bus_start();
         send_byte({a[6:0], 1'b0}, ack);
         bus_stop();
         chk(ack == (a == int'(DEV)), "R2 device match", int'(ack), int'(a == int'(DEV)));
      end

      // R3 read direction refused
      bus_start();
      send_byte({DEV, 1'b1}, ack);
      bus_stop();
      chk(!ack, "R3 read refused", int'(ack), 0);

      // R4 register range, R5 single write, R7 ignore after refusal
      for (int r = 0; r < 44; r++) begin
         int ra;
         logic okr;
         ra = (r < 40) ? r : (r == 40 ? NREG - 1 : (r == 41 ? NREG : (r == 42 ? 128 : 255)));
         okr = (ra < NREG);
         n0 = ncap;
         bus_start();
         send_byte({DEV, 1'b0}, ack);
         send_byte(8'(ra), ack);
         chk(ack == okr, "R4 register ack", int'(ack), int'(okr));
         send_byte(8'(ra) ^ 8'h5A, ack);
         if (okr) begin
            chk(ack && ncap == n0 + 1, "R5 data ack and strobe", ncap - n0, 1);
            chk(cap_a[n0 % 64] == 8'(ra) && cap_d[n0 % 64] == (8'(ra) ^ 8'h5A),
                "R5 strobe fields", int'(cap_d[n0 % 64]), int'(8'(ra) ^ 8'h5A));
         end else begin
            chk(!ack && ncap == n0, "R7 ignored after refusal", ncap - n0, 0);
         end
         bus_stop();
         chk(!sda_oe, "R9 released after stop", int'(sda_oe), 0);
      end

      // R6 burst
      n0 = ncap;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd18, ack);
      for (int k = 0; k < 6; k++) begin
         send_byte(8'h30 + 8'(k), ack);
         chk(ack, "R5 burst byte ack", int'(ack), 1);
      end
      bus_stop();
      chk(ncap == n0 + 6, "R6 burst count", ncap - n0, 6);
      for (int k = 0; k < 6; k++) begin
         chk(cap_a[(n0 + k) % 64] == 8'd18 + 8'(k) && cap_d[(n0 + k) % 64] == 8'h30 + 8'(k),
             "R6 burst address step", int'(cap_a[(n0 + k) % 64]), 18 + k);
      end

      // R8 repeated start after a refused address
      n0 = ncap;
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, ack);
      chk(!ack, "R8 foreign address refused", int'(ack), 0);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      chk(ack, "R8 match after repeated start", int'(ack), 1);
      send_byte(8'd3, ack);
      send_byte(8'hC3, ack);
      bus_stop();
      chk(ncap == n0 + 1 && cap_a[n0 % 64] == 8'd3 && cap_d[n0 % 64] == 8'hC3,
          "R8 write after repeated start", ncap - n0, 1);

      // R9 stop in the middle of a data byte
      n0 = ncap;
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd4, ack);
      begin
         logic o;
         for (int i = 0; i < 4; i++) put_bit(1'b1, o);
      end
      bus_stop();
      chk(ncap == n0, "R9 partial byte dropped", ncap - n0, 0);
      bus_start();
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'd5, ack);
      send_byte(8'h77, ack);
      bus_stop();
      chk(ncap == n0 + 1 && cap_a[n0 % 64] == 8'd5, "R9 recovery after stop", ncap - n0, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule